// File: doc/BRIEF.md
# Serial Booth Signed Multiplier

This block forms the signed product of two 32-bit words one Booth step per clock. A start strobe loads the multiplier into the low half register, clears the high half (the accumulator), clears the remembered shifted-out bit and captures the multiplicand. Each following cycle looks at the remembered bit and the low bit of the low half. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. It then shifts the accumulator:low pair one place right, arithmetically.

The number of steps comes from a 6-bit count loaded at start. The count is incremented once per step and the run ends on the step that wraps it to zero. A count of 32 therefore gives the full 64-bit product, with the upper word in the accumulator and the lower word in the low half. A count of 0 gives 64 steps. The control is a three-state machine. In IDLE the block waits for start and goes to RUN. In RUN it steps and goes to DONE on the wrapping step. DONE lasts one cycle, raises the done flag and always returns to IDLE.

Top module: `booth_serial_mul`

## Requirements
- R1: After reset, busy and done are 0, and both the accumulator and the low half read 0.
- R2: A start seen in IDLE loads the multiplier into the low half and clears the accumulator and the remembered bit. Busy is 1 from the next cycle.
- R3: With remembered bit 1 and low bit 0, the multiplicand is added to the accumulator before the shift.
- R4: With remembered bit 0 and low bit 1, the multiplicand is subtracted from the accumulator before the shift.
- R5: With equal bits the accumulator is not changed before the shift, and the step still takes a full cycle.
- R6: Each step shifts the pair right by one. The accumulator keeps its sign bit, its low bit enters bit 31 of the low half, and the old low bit becomes the remembered bit.
- R7: The run lasts (64 - count) mod 64 cycles, and a count of 0 means 64 cycles. Busy is 1 during exactly those cycles.
- R8: Done is 1 for exactly one cycle, directly after the last step. Outside RUN the outputs hold their values.
- R9: A start while busy or done is ignored. The running product and its length are unaffected.
- R10: With a count of 32 and a multiplicand other than -2^31, the pair holds the 64-bit two's-complement product.
- R11: Additions and subtractions wrap modulo 2^32 and no overflow indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; used only in IDLE |
| mplier_in | input | 32 | Multiplier, loaded into the low half |
| mcand_in | input | 32 | Signed multiplicand, captured at start |
| steps_in | input | 6 | Initial value of the step count |
| acc_o | output | 32 | Accumulator, upper half of the result |
| low_o | output | 32 | Low half, lower half of the result |
| busy_o | output | 1 | High while steps are being taken |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take it that start is only meant to begin a run from IDLE. They also take it that the product relation holds only when the multiplicand is not the most negative word, because the accumulator has no guard bit. The bench keeps random multiplicands away from 0x80000000 and uses short counts with small operands when it checks partial runs. Starts sent during a run are checked at the ports, through the product value and the cycle count.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_t;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_mul_pkg::*;
(
    input  logic      prev_bit,
    input  logic      cur_bit,
    output booth_op_t op
);
    always_comb begin
        unique case ({prev_bit, cur_bit})
            2'b10:   op = OP_ADD;
            2'b01:   op = OP_SUB;
            default: op = OP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_step_counter.sv
module booth_step_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] init,
    output logic             last
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= init;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // the step taken while the count sits at all ones wraps it to zero
    assign last = (cnt_q == TOP);
endmodule

// File: rtl/booth_step_dp.sv
module booth_step_dp
    import booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mplier,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] acc,
    output logic [W-1:0] low,
    output logic         prev
);
    logic [W-1:0] acc_q, low_q, mcand_q, sum;
    logic         prev_q;
    booth_op_t    op;

    booth_recode u_recode (
        .prev_bit (prev_q),
        .cur_bit  (low_q[0]),
        .op       (op)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  sum = acc_q + mcand_q;
            OP_SUB:  sum = acc_q - mcand_q;
            default: sum = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            low_q   <= '0;
            mcand_q <= '0;
            prev_q  <= 1'b0;
        end else if (load) begin
            acc_q   <= '0;
            low_q   <= mplier;
            mcand_q <= mcand;
            prev_q  <= 1'b0;
        end else if (step) begin
            acc_q  <= {sum[W-1], sum[W-1:1]};
            low_q  <= {sum[0], low_q[W-1:1]};
            prev_q <= low_q[0];
        end
    end

    assign acc  = acc_q;
    assign low  = low_q;
    assign prev = prev_q;
endmodule

// File: rtl/booth_serial_mul.sv
module booth_serial_mul
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] mplier_in,
    input  logic [WIDTH-1:0] mcand_in,
    input  logic [CNT_W-1:0] steps_in,
    output logic [WIDTH-1:0] acc_o,
    output logic [WIDTH-1:0] low_o,
    output logic             busy_o,
    output logic             done_o
);
    mul_state_t state_q, state_d;
    logic       load, step, last, prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  begin step = 1'b1; busy_o = 1'b1; end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    booth_step_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .init  (steps_in),
        .last  (last)
    );

    booth_step_dp #(.W(WIDTH)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mplier (mplier_in),
        .mcand  (mcand_in),
        .acc    (acc_o),
        .low    (low_o),
        .prev   (prev_q)
    );
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] acc_o,
    input logic [W-1:0] low_o,
    input logic         busy_o,
    input logic         done_o,
    input logic         prev_bit
);
    a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_o && !done_o) |=> (busy_o && acc_o == '0));

    a_r6_low_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (low_o[W-2:0] == $past(low_o[W-1:1])));

    a_r5_keep_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (low_o[0] == prev_bit)) |=>
        (acc_o == {$past(acc_o[W-1]), $past(acc_o[W-1:1])} && low_o[W-1] == $past(acc_o[0])));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || (!busy_o && !start)) |=> ($stable(acc_o) && $stable(low_o)));
endmodule

bind booth_serial_mul booth_mul_chk #(.W(WIDTH)) u_booth_mul_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .acc_o    (acc_o),
    .low_o    (low_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .prev_bit (prev_q)
);

// File: tb/test_booth_serial_mul.sv
`timescale 1ns/1ps
module test_booth_serial_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mplier_in = '0, mcand_in = '0;
    logic [5:0]  steps_in = '0;
    logic [31:0] acc_o, low_o;
    logic        busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    booth_serial_mul i_booth_serial_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mplier_in(mplier_in), .mcand_in(mcand_in), .steps_in(steps_in),
        .acc_o(acc_o), .low_o(low_o), .busy_o(busy_o), .done_o(done_o)
    );

    localparam int NVEC = 8;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0003, 32'h0000_0005},
        {32'hFFFF_FFFD, 32'h0000_0007},
        {32'h0000_0009, 32'hFFFF_FFF6},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'h7FFF_FFFF},
        {32'h7FFF_FFFF, 32'h8000_0001},
        {32'h0000_0000, 32'h1234_5678},
        {32'h5555_5555, 32'hAAAA_AAAB}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] full_prod(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] p;
        p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        return p;
    endfunction

    // pair value after k steps: (signed low k bits * mcand * 2^32 + mplier) >>> k
    function automatic logic [63:0] part_prod(input logic [31:0] mp, input logic [31:0] mc, input int k);
        logic signed [95:0] s, m, tot;
        s = $signed({mp, 64'b0} << (32 - k)) >>> (96 - k);
        m = $signed({{64{mc[31]}}, mc});
        tot = ((s * m) <<< 32) + $signed({64'b0, mp});
        tot = tot >>> k;
        return tot[63:0];
    endfunction

    // start a run; returns the number of busy cycles seen before done
    task automatic run(input logic [31:0] mp, input logic [31:0] mc, input logic [5:0] st,
                       input bit poke, output int cyc);
        @(negedge clk);
        mplier_in = mp; mcand_in = mc; steps_in = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy_o && cyc < 100) begin
            cyc++;
            if (poke && cyc == 3) begin
                mplier_in = 32'h0F0F_0F0F; mcand_in = 32'h0000_0123; steps_in = 6'd60; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        if (poke) begin
            start = 1'b1;  // also offered while done is high
        end
        check(done_o === 1'b1, "R8 done after last step", {63'b0, done_o}, 64'd1);
        @(negedge clk);
        start = 1'b0;
        check(done_o === 1'b0 && busy_o === 1'b0, "R8 done single cycle",
              {62'b0, done_o, busy_o}, 64'd0);
    endtask

    initial begin
        int cyc;
        logic [63:0] exp, held;
        #12;
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags at reset", {62'b0, busy_o, done_o}, 64'd0);
        check({acc_o, low_o} === 64'd0, "R1 data at reset", {acc_o, low_o}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i][63:32], VEC[i][31:0], 6'd32, 1'b0, cyc);
            exp = full_prod(VEC[i][63:32], VEC[i][31:0]);
            check({acc_o, low_o} === exp, "R10 table product", {acc_o, low_o}, exp);
            check(cyc == 32, "R7 32 step run", 64'(cyc), 64'd32);
        end

        for (int i = 0; i < 20; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (b == 32'h8000_0000) b = 32'h8000_0001;
            run(a, b, 6'd32, 1'b0, cyc);
            exp = full_prod(a, b);
            check({acc_o, low_o} === exp, "R10 R11 random product", {acc_o, low_o}, exp);
        end

        // R3: remembered bit 1 with low bit 0 on step two adds (mplier ..01, 2 steps)
        run(32'h0000_0001, 32'h0000_0064, 6'd62, 1'b0, cyc);
        exp = part_prod(32'h0000_0001, 32'h0000_0064, 2);
        check({acc_o, low_o} === exp, "R3 add step", {acc_o, low_o}, exp);
        check(cyc == 2, "R7 two steps", 64'(cyc), 64'd2);

        // R4 and R6: single subtract step then shift
        run(32'h0000_0001, 32'h0000_000A, 6'd63, 1'b0, cyc);
        check({acc_o, low_o} === 64'hFFFF_FFFB_0000_0000, "R4 R6 subtract and shift",
              {acc_o, low_o}, 64'hFFFF_FFFB_0000_0000);
        check(cyc == 1, "R7 count 63 gives one step", 64'(cyc), 64'd1);

        // R5: all-equal pairs leave the accumulator but take full time
        run(32'h0000_0000, 32'h7654_3210, 6'd59, 1'b0, cyc);
        check({acc_o, low_o} === 64'd0, "R5 keep steps", {acc_o, low_o}, 64'd0);
        check(cyc == 5, "R5 cycles consumed", 64'(cyc), 64'd5);

        // R6: three steps on a small mixed pattern
        run(32'h0000_0005, 32'h0000_0007, 6'd61, 1'b0, cyc);
        exp = part_prod(32'h0000_0005, 32'h0000_0007, 3);
        check({acc_o, low_o} === exp, "R6 three step pair", {acc_o, low_o}, exp);

        // R7: count 0 runs 64 steps
        run(32'h0000_0003, 32'h0000_0002, 6'd0, 1'b0, cyc);
        check(cyc == 64, "R7 count 0 gives 64 steps", 64'(cyc), 64'd64);

        // R9: starts offered during busy and done are ignored
        run(32'hFFFF_FF00, 32'h0000_1000, 6'd32, 1'b1, cyc);
        exp = full_prod(32'hFFFF_FF00, 32'h0000_1000);
        check({acc_o, low_o} === exp, "R9 product kept", {acc_o, low_o}, exp);
        check(cyc == 32, "R9 length kept", 64'(cyc), 64'd32);

        // R8: idle outputs hold and R2: next start clears the accumulator
        held = {acc_o, low_o};
        repeat (3) @(negedge clk);
        check({acc_o, low_o} === held, "R8 idle hold", {acc_o, low_o}, held);
        mplier_in = 32'hCAFE_0001; mcand_in = 32'h3; steps_in = 6'd32; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy_o === 1'b1 && acc_o === 32'd0 && low_o === 32'hCAFE_0001, "R2 load",
              {acc_o, low_o}, {32'd0, 32'hCAFE_0001});
        while (busy_o) @(negedge clk);
        @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule